// File: doc/BRIEF.md
# Scan-List Acquisition Sequencer with Level Thresholds

This block drives a multi-channel sampling engine from a programmable list of up to 64 scan entries. Each entry names an input channel (0 to 47), a 2-bit gain code, a single-ended or differential input mode, a threshold comparison mode, and a flag that closes the pass. Each time a sample tick arrives while the block waits, it presents the current entry's selection to an external converter and pulses a start strobe. When the converter returns a 16-bit result, the block writes it to an external 64K x 16 data buffer at a running address. It also checks the result against that entry's own high and low thresholds.

The tick comes from one of three sources: a 24-bit internal divider, host writes to the start register, or rising edges on an external strobe. A run ends in one of three ways. It ends when the buffer address reaches an end pointer, or after a programmed number of completed passes. It also ends on a host stop command. Optional interrupt pulses mark the start of each pass, a store at a chosen buffer address, and every threshold hit. Each channel has a sticky status bit that records a hit.

In threshold-armed mode the sequencer holds on an entry that has comparison enabled and converts its channel again and again. It moves on only after the entry's condition is met. Once that happens, the rest of the run proceeds normally. Configuration, the scan list and both threshold tables are loaded through a write-only host port.

Top module: `scan_acq_seq`

## Requirements
- R1: After reset `running`, `convStart`, `bufWe`, all three interrupts and every `levelStatus` bit are 0, and `bufAddr` is 0.
- R2: Host map: writing 0x40+i loads scan entry i, 0x80+i loads high threshold i and 0xC0+i loads low threshold i (12 bits each). An entry is {bit11 last-of-pass, bits10:9 threshold mode, bit8 differential, bits7:6 gain, bits5:0 channel}. Entries run in order from 0, and after an entry marked last (or entry 63) the next one is entry 0. While an entry is current, its fields appear on `convCh`, `convGain` and `convDiff`, and `convStart` pulses for one cycle per tick.
- R3: In the cycle when `convDone` is high, `bufWe` is high, `bufData` equals `convData` and `bufAddr` is the store address. The address then increases by one, or returns to 0 if the run ends.
- R4: The comparison uses the top 12 bits of the sample. Mode 00 never hits. Mode 01 hits above the high threshold. Mode 10 hits below the low threshold. Mode 11 hits when the value lies between the low and high thresholds, both inclusive. A hit pulses `levelIrq` in the store cycle and sets `levelStatus[channel]`.
- R5: Status bit c is cleared only by writing 1 to data bit c%16 at address 0x09+c/16. A 0 bit leaves the status unchanged, and a host write is the only thing that clears any status bit.
- R6: Control register 0x00 bits1:0 pick the tick source. 00 is the internal divider, which ticks every N+1 cycles, where N = {reg 0x02 bits7:0, reg 0x01}. 01 is each host write to 0x07 made while running. 10 is each rising edge of `extStrobe`. A tick that arrives while a conversion is outstanding, or while idle, has no effect.
- R7: A write to 0x07 while idle starts a run from entry 0 at address 0. With control bit2 = 0, the store at the address held in register 0x03 is the last one. `running` then drops and `bufAddr` returns to 0.
- R8: With control bit2 = 1, the run ends after the pass that brings the count of completed passes to the value in register 0x05. The end pointer is not used in this case.
- R9: A write to 0x08 ends the run at once. A result that arrives in that cycle or later is not stored.
- R10: With control bit3 = 1, `scanIrq` pulses together with `convStart` for entry 0 at the start of each pass. With the bit at 0, it stays low.
- R11: With control bit4 = 1, `ptrIrq` pulses in the store cycle whose address equals register 0x04.
- R12: With control bit5 = 1, an entry whose mode is not 00 is converted again until its first hit in the run. The repeats do not raise `scanIrq` again. After that first hit, no entry repeats for the rest of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 8 | Host write address |
| hostWdata | input | 16 | Host write data |
| extStrobe | input | 1 | External sample strobe |
| convStart | output | 1 | Converter start pulse |
| convCh | output | 6 | Channel select of the current entry |
| convGain | output | 2 | Gain code of the current entry |
| convDiff | output | 1 | 1 = differential input |
| convDone | input | 1 | Converter result valid |
| convData | input | 16 | Converter result |
| bufWe | output | 1 | Data buffer write enable |
| bufAddr | output | 16 | Data buffer address |
| bufData | output | 16 | Data buffer write data |
| running | output | 1 | Acquisition active |
| levelStatus | output | 48 | Sticky per-channel threshold hit bits |
| levelIrq | output | 1 | Threshold hit pulse |
| scanIrq | output | 1 | Pass start pulse |
| ptrIrq | output | 1 | Interrupt pointer store pulse |

## Verification
The hardest case to reach is threshold-armed repetition. The stimulus has to send results that miss on one entry several times and then hit. It must then show that the next entry advances normally and that the pass-start interrupt did not fire again during the repeats. The bench feeds a per-sample data queue to a converter model so that each result is chosen to miss or hit. A scoreboard predicts every conversion and every store. A second hard case is a stop write that lands in the very cycle the converter answers. The bench reaches it by timing the stop write to the converter model's fixed latency, and expects no store.

// File: rtl/scan_acq_pkg.sv
package scan_acq_pkg;
  localparam int CH_FIELD_W = 6;
  localparam int TH_FIELD_W = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CONV} seqState_t;
  typedef enum logic [1:0] {SRC_DIV, SRC_HOST, SRC_STROBE, SRC_NONE} tickSrc_t;
  typedef enum logic [1:0] {TH_OFF, TH_ABOVE, TH_BELOW, TH_INSIDE} thMode_t;

  typedef struct packed {
    logic                  last;
    thMode_t               mode;
    logic                  diff;
    logic [1:0]            gain;
    logic [CH_FIELD_W-1:0] ch;
  } scanEntry_t;

  typedef struct packed {
    logic restart;
    logic issue;
    logic accept;
  } seqCmd_t;
endpackage

// File: rtl/scan_acq_ctrl.sv
module scan_acq_ctrl
  import scan_acq_pkg::*;
#(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startWr,
  input  logic             stopWr,
  input  tickSrc_t         clkSrc,
  input  logic [DIV_W-1:0] divisor,
  input  logic             extStrobe,
  input  logic             convDone,
  input  logic             runEnd,
  output seqCmd_t          cmd,
  output logic             running
);
  seqState_t        state, nextState;
  logic [DIV_W-1:0] divCnt;
  logic             strobePrev, divTick, tick;

  assign running = (state != ST_IDLE);
  assign divTick = running && (divCnt == divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt     <= '0;
      strobePrev <= 1'b0;
      state      <= ST_IDLE;
    end else begin
      strobePrev <= extStrobe;
      state      <= nextState;
      if (!running || divTick) divCnt <= '0;
      else                     divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (clkSrc)
      SRC_DIV:    tick = divTick;
      SRC_HOST:   tick = startWr;
      SRC_STROBE: tick = extStrobe && !strobePrev;
      default:    tick = 1'b0;
    endcase
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: if (startWr) begin
        cmd.restart = 1'b1;
        nextState   = ST_WAIT;
      end
      ST_WAIT: begin
        if (stopWr) nextState = ST_IDLE;
        else if (tick) begin
          cmd.issue = 1'b1;
          nextState = ST_CONV;
        end
      end
      ST_CONV: begin
        if (stopWr) nextState = ST_IDLE;
        else if (convDone) begin
          cmd.accept = 1'b1;
          nextState  = runEnd ? ST_IDLE : ST_WAIT;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/scan_acq_dp.sv
module scan_acq_dp
  import scan_acq_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int CH_COUNT = 48,
  parameter int DATA_W   = 16,
  parameter int BUF_AW   = 16,
  parameter int DIV_W    = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [7:0]        hostAddr,
  input  logic [15:0]       hostWdata,
  input  seqCmd_t           cmd,
  input  logic [DATA_W-1:0] convData,
  output scanEntry_t        curEntry,
  output logic              startWr,
  output logic              stopWr,
  output tickSrc_t          clkSrc,
  output logic [DIV_W-1:0]  divisor,
  output logic              runEnd,
  output logic [BUF_AW-1:0] bufAddr,
  output logic [CH_COUNT-1:0] levelStatus,
  output logic              levelIrq,
  output logic              ptrIrq,
  output logic              scanIrq
);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int TH_W    = TH_FIELD_W;
  localparam int ENT_W   = $bits(scanEntry_t);
  localparam int HI_W    = DIV_W - 16;
  localparam logic [7:0] CLR_BASE = 8'h09;

  logic [ENT_W-1:0] scanMem [ENTRIES];
  logic [TH_W-1:0]  hiMem   [ENTRIES];
  logic [TH_W-1:0]  loMem   [ENTRIES];

  logic [5:0]        ctrlReg;
  logic [15:0]       divLo, scanLimit, scanCnt;
  logic [HI_W-1:0]   divHi;
  logic [BUF_AW-1:0] endPtr, irqPtr;
  logic [IDX_W-1:0]  idx;
  logic              armFired, lastStay;
  logic [TH_W-1:0]   sampTop, hiTh, loTh;
  logic              hit, stay, lastIdx;
  logic [CH_COUNT-1:0] clrMask, setMask;

  assign clkSrc  = tickSrc_t'(ctrlReg[1:0]);
  assign divisor = {divHi, divLo};
  assign startWr = hostWe && (hostAddr == 8'h07);
  assign stopWr  = hostWe && (hostAddr == 8'h08);

  always_ff @(posedge clk) begin
    if (hostWe) begin
      unique case (hostAddr[7:6])
        2'b01:   scanMem[hostAddr[IDX_W-1:0]] <= hostWdata[ENT_W-1:0];
        2'b10:   hiMem[hostAddr[IDX_W-1:0]]   <= hostWdata[TH_W-1:0];
        2'b11:   loMem[hostAddr[IDX_W-1:0]]   <= hostWdata[TH_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      divLo     <= '0;
      divHi     <= '0;
      endPtr    <= '0;
      irqPtr    <= '0;
      scanLimit <= '0;
    end else if (hostWe) begin
      unique case (hostAddr)
        8'h00:   ctrlReg   <= hostWdata[5:0];
        8'h01:   divLo     <= hostWdata;
        8'h02:   divHi     <= hostWdata[HI_W-1:0];
        8'h03:   endPtr    <= hostWdata[BUF_AW-1:0];
        8'h04:   irqPtr    <= hostWdata[BUF_AW-1:0];
        8'h05:   scanLimit <= hostWdata;
        default: ;
      endcase
    end
  end

  assign curEntry = scanEntry_t'(scanMem[idx]);
  assign sampTop  = convData[DATA_W-1 -: TH_W];
  assign hiTh     = hiMem[idx];
  assign loTh     = loMem[idx];

  always_comb begin
    unique case (curEntry.mode)
      TH_ABOVE:  hit = sampTop > hiTh;
      TH_BELOW:  hit = sampTop < loTh;
      TH_INSIDE: hit = (sampTop >= loTh) && (sampTop <= hiTh);
      default:   hit = 1'b0;
    endcase
  end

  assign stay    = ctrlReg[5] && !armFired && (curEntry.mode != TH_OFF) && !hit;
  assign lastIdx = curEntry.last || (idx == IDX_W'(ENTRIES - 1));
  assign runEnd  = ctrlReg[2] ? (!stay && lastIdx && (scanCnt + 16'd1 == scanLimit))
                              : (bufAddr == endPtr);

  assign levelIrq = cmd.accept && hit;
  assign ptrIrq   = cmd.accept && ctrlReg[4] && (bufAddr == irqPtr);
  assign scanIrq  = cmd.issue && ctrlReg[3] && (idx == '0) && !lastStay;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx      <= '0;
      bufAddr  <= '0;
      scanCnt  <= '0;
      armFired <= 1'b0;
      lastStay <= 1'b0;
    end else if (cmd.restart) begin
      idx      <= '0;
      bufAddr  <= '0;
      scanCnt  <= '0;
      armFired <= 1'b0;
      lastStay <= 1'b0;
    end else if (cmd.accept) begin
      bufAddr  <= runEnd ? '0 : bufAddr + 1'b1;
      lastStay <= stay;
      if (hit && ctrlReg[5]) armFired <= 1'b1;
      if (!stay) begin
        idx <= lastIdx ? '0 : idx + 1'b1;
        if (lastIdx) scanCnt <= scanCnt + 16'd1;
      end
    end
  end

  for (genvar b = 0; b < CH_COUNT; b++) begin : g_status
    assign clrMask[b] = hostWe && (hostAddr == CLR_BASE + 8'(b / 16)) && hostWdata[b % 16];
    assign setMask[b] = levelIrq && (curEntry.ch == CH_FIELD_W'(b));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelStatus <= '0;
    else       levelStatus <= (levelStatus & ~clrMask) | setMask;
  end
endmodule

// File: rtl/scan_acq_seq.sv
module scan_acq_seq
  import scan_acq_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int CH_COUNT = 48,
  parameter int DATA_W   = 16,
  parameter int BUF_AW   = 16,
  parameter int DIV_W    = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostWe,
  input  logic [7:0]            hostAddr,
  input  logic [15:0]           hostWdata,
  input  logic                  extStrobe,
  output logic                  convStart,
  output logic [CH_FIELD_W-1:0] convCh,
  output logic [1:0]            convGain,
  output logic                  convDiff,
  input  logic                  convDone,
  input  logic [DATA_W-1:0]     convData,
  output logic                  bufWe,
  output logic [BUF_AW-1:0]     bufAddr,
  output logic [DATA_W-1:0]     bufData,
  output logic                  running,
  output logic [CH_COUNT-1:0]   levelStatus,
  output logic                  levelIrq,
  output logic                  scanIrq,
  output logic                  ptrIrq
);
  seqCmd_t          cmd;
  scanEntry_t       curEntry;
  tickSrc_t         clkSrc;
  logic [DIV_W-1:0] divisor;
  logic             startWr, stopWr, runEnd;

  scan_acq_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startWr(startWr), .stopWr(stopWr),
    .clkSrc(clkSrc), .divisor(divisor), .extStrobe(extStrobe),
    .convDone(convDone), .runEnd(runEnd), .cmd(cmd), .running(running)
  );

  scan_acq_dp #(
    .ENTRIES(ENTRIES), .CH_COUNT(CH_COUNT), .DATA_W(DATA_W),
    .BUF_AW(BUF_AW), .DIV_W(DIV_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .cmd(cmd), .convData(convData),
    .curEntry(curEntry), .startWr(startWr), .stopWr(stopWr),
    .clkSrc(clkSrc), .divisor(divisor), .runEnd(runEnd),
    .bufAddr(bufAddr), .levelStatus(levelStatus), .levelIrq(levelIrq),
    .ptrIrq(ptrIrq), .scanIrq(scanIrq)
  );

  assign convStart = cmd.issue;
  assign convCh    = curEntry.ch;
  assign convGain  = curEntry.gain;
  assign convDiff  = curEntry.diff;
  assign bufWe     = cmd.accept;
  assign bufData   = convData;
endmodule

// File: rtl/scan_acq_chk.sv
module scan_acq_chk #(
  parameter int CH_COUNT = 48,
  parameter int BUF_AW   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                hostWe,
  input logic [7:0]          hostAddr,
  input logic                convStart,
  input logic                bufWe,
  input logic [BUF_AW-1:0]   bufAddr,
  input logic                running,
  input logic [CH_COUNT-1:0] levelStatus,
  input logic                levelIrq,
  input logic                scanIrq,
  input logic                ptrIrq
);
  a_r2_single_start: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  a_r3_store_while_running: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> running);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |=> (bufAddr == $past(bufAddr) + 1'b1) || (bufAddr == '0));

  a_r4_level_on_store: assert property (@(posedge clk) disable iff (!rstN)
    levelIrq |-> bufWe);

  a_r5_sticky_status: assert property (@(posedge clk) disable iff (!rstN)
    !hostWe |=> ((levelStatus & $past(levelStatus)) == $past(levelStatus)));

  a_r7_run_end_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> ($past(hostWe && hostAddr == 8'h08) || $past(bufWe)));

  a_r10_scan_with_start: assert property (@(posedge clk) disable iff (!rstN)
    scanIrq |-> convStart);

  a_r11_ptr_on_store: assert property (@(posedge clk) disable iff (!rstN)
    ptrIrq |-> bufWe);
endmodule

bind scan_acq_seq scan_acq_chk #(.CH_COUNT(CH_COUNT), .BUF_AW(BUF_AW)) u_chk (
  .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
  .convStart(convStart), .bufWe(bufWe), .bufAddr(bufAddr), .running(running),
  .levelStatus(levelStatus), .levelIrq(levelIrq), .scanIrq(scanIrq), .ptrIrq(ptrIrq)
);

// File: tb/scan_acq_seq_tb.sv
`timescale 1ns/100ps
module scan_acq_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic        extStrobe = 1'b0;
  logic        convDone = 1'b0;
  logic [15:0] convData = '0;
  logic        convStart, convDiff, bufWe, running, levelIrq, scanIrq, ptrIrq;
  logic [5:0]  convCh;
  logic [1:0]  convGain;
  logic [15:0] bufAddr, bufData;
  logic [47:0] levelStatus;

  always #2.5 clk = ~clk;

  scan_acq_seq u_dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .extStrobe(extStrobe), .convStart(convStart),
    .convCh(convCh), .convGain(convGain), .convDiff(convDiff),
    .convDone(convDone), .convData(convData), .bufWe(bufWe),
    .bufAddr(bufAddr), .bufData(bufData), .running(running),
    .levelStatus(levelStatus), .levelIrq(levelIrq), .scanIrq(scanIrq),
    .ptrIrq(ptrIrq)
  );

  int nChecks = 0, nFail = 0, cyc = 0;
  int nScan = 0, nPtr = 0, nLevel = 0, nStore = 0;
  bit finished = 0;
  logic [8:0]  convQ[$];
  logic [31:0] storeQ[$];
  logic [15:0] dataQ[$];
  int          startTimes[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkEntry(input bit last, input logic [1:0] mode,
                                          input bit diff, input logic [1:0] gain,
                                          input logic [5:0] ch);
    return {4'h0, last, mode, diff, gain, ch};
  endfunction

  task automatic hostWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic expectSample(input logic [5:0] ch, input logic [1:0] gain, input bit diff,
                              input logic [15:0] addr, input logic [15:0] data);
    convQ.push_back({ch, gain, diff});
    dataQ.push_back(data);
    storeQ.push_back({addr, data});
  endtask

  task automatic tickHost();
    hostWrite(8'h07, 16'h0);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseStrobe();
    @(negedge clk); extStrobe = 1'b1;
    @(negedge clk); extStrobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic waitIdle(input int maxCyc);
    for (int i = 0; i < maxCyc && running; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clearCounts();
    nScan = 0; nPtr = 0; nLevel = 0;
  endtask

  // converter model: fixed latency, data taken from dataQ
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (cnt == 1) begin
        convDone = 1'b1;
        convData = (dataQ.size() != 0) ? dataQ.pop_front() : 16'hDEAD;
      end else convDone = 1'b0;
      if (cnt > 0) cnt--;
      #1;
      if (convStart) cnt = 2;
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (convStart) begin
        startTimes.push_back(cyc);
        if (convQ.size() == 0) chk("R2 unexpected conversion start", 1, 0);
        else chk("R2 entry select ch/gain/diff", {convCh, convGain, convDiff}, convQ.pop_front());
      end
      if (bufWe) begin
        nStore++;
        if (storeQ.size() == 0) chk("R3 unexpected store", 1, 0);
        else chk("R3 store addr/data", {bufAddr, bufData}, storeQ.pop_front());
      end
      if (scanIrq) nScan++;
      if (ptrIrq) nPtr++;
      if (levelIrq) nLevel++;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 running at reset", running, 0);
    chk("R1 convStart at reset", convStart, 0);
    chk("R1 bufAddr at reset", bufAddr, 0);
    chk("R1 levelStatus at reset", levelStatus, 0);
    chk("R1 irqs at reset", {bufWe, levelIrq, scanIrq, ptrIrq}, 0);
    @(negedge clk); rstN = 1'b1;

    // ---- Test A: host ticks, end pointer, irqs, thresholds (R2 R3 R4 R7 R10 R11)
    hostWrite(8'h40, mkEntry(0, 2'b01, 0, 2'd1, 6'd5));
    hostWrite(8'h41, mkEntry(0, 2'b10, 1, 2'd2, 6'd20));
    hostWrite(8'h42, mkEntry(0, 2'b11, 0, 2'd3, 6'd47));
    hostWrite(8'h43, mkEntry(1, 2'b00, 1, 2'd0, 6'd33));
    hostWrite(8'h80, 16'h800);
    hostWrite(8'hC1, 16'h100);
    hostWrite(8'hC2, 16'h100);
    hostWrite(8'h82, 16'h300);
    hostWrite(8'h00, 16'h0019);
    hostWrite(8'h03, 16'd5);
    hostWrite(8'h04, 16'd2);
    expectSample(6'd5,  2'd1, 0, 16'd0, 16'h9000); // above hi: hit
    expectSample(6'd20, 2'd2, 1, 16'd1, 16'h2000); // not below lo
    expectSample(6'd47, 2'd3, 0, 16'd2, 16'h3000); // inside, inclusive hi: hit
    expectSample(6'd33, 2'd0, 1, 16'd3, 16'hFFFF); // mode off
    expectSample(6'd5,  2'd1, 0, 16'd4, 16'h1000); // no hit
    expectSample(6'd20, 2'd2, 1, 16'd5, 16'h0F00); // below lo: hit
    clearCounts();
    hostWrite(8'h07, 16'h0);
    repeat (6) tickHost();
    #1;
    chk("R7 running cleared at end pointer", running, 0);
    chk("R7 bufAddr back to zero", bufAddr, 0);
    chk("R10 one scanIrq per pass", nScan, 2);
    chk("R11 ptrIrq at pointer", nPtr, 1);
    chk("R4 levelIrq count", nLevel, 3);
    chk("R4 status bits ch5/20/47", levelStatus, (48'd1 << 5) | (48'd1 << 20) | (48'd1 << 47));

    // ---- R5 write-one-to-clear
    hostWrite(8'h09, 16'h0020);
    hostWrite(8'h0A, 16'h0000);
    #1;
    chk("R5 clear ch5 only, zero write ignored", levelStatus, (48'd1 << 20) | (48'd1 << 47));
    hostWrite(8'h0A, 16'h0010);
    hostWrite(8'h0B, 16'h8000);
    #1;
    chk("R5 all status cleared", levelStatus, 0);

    // ---- Test B: strobe ticks, scan count end (R6 R8 R10)
    hostWrite(8'h41, mkEntry(1, 2'b10, 1, 2'd2, 6'd20));
    hostWrite(8'h00, 16'h0006);
    hostWrite(8'h05, 16'd2);
    hostWrite(8'h03, 16'd1);
    expectSample(6'd5,  2'd1, 0, 16'd0, 16'h1000);
    expectSample(6'd20, 2'd2, 1, 16'd1, 16'h5000);
    expectSample(6'd5,  2'd1, 0, 16'd2, 16'h2000);
    expectSample(6'd20, 2'd2, 1, 16'd3, 16'h6000);
    clearCounts();
    hostWrite(8'h07, 16'h0);
    repeat (4) pulseStrobe();
    #1;
    chk("R8 running cleared after 2 passes", running, 0);
    chk("R8 bufAddr back to zero", bufAddr, 0);
    pulseStrobe();
    chk("R6 strobe while idle ignored", convQ.size(), 0);
    chk("R10 scanIrq disabled", nScan, 0);
    chk("R4 no hits for in-range samples", nLevel, 0);

    // ---- Test E: threshold-armed repetition (R12)
    hostWrite(8'h00, 16'h002D);
    hostWrite(8'h05, 16'd1);
    expectSample(6'd5,  2'd1, 0, 16'd0, 16'h1000);
    expectSample(6'd5,  2'd1, 0, 16'd1, 16'h2000);
    expectSample(6'd5,  2'd1, 0, 16'd2, 16'h9000);
    expectSample(6'd20, 2'd2, 1, 16'd3, 16'h5000);
    clearCounts();
    hostWrite(8'h07, 16'h0);
    repeat (4) tickHost();
    #1;
    chk("R12 run ends after armed pass", running, 0);
    chk("R12 repeats do not raise scanIrq", nScan, 1);
    chk("R12 single hit", nLevel, 1);
    chk("R12 status ch5", levelStatus, 48'd1 << 5);

    // ---- Test D: stop in the converter's answer cycle (R9)
    hostWrite(8'h00, 16'h0001);
    hostWrite(8'h03, 16'h0100);
    convQ.push_back({6'd5, 2'd1, 1'b0});
    dataQ.push_back(16'h1234);
    nStore = 0;
    hostWrite(8'h07, 16'h0);
    hostWrite(8'h07, 16'h0);
    hostWrite(8'h08, 16'h0);
    repeat (6) @(negedge clk);
    #1;
    chk("R9 running cleared by stop", running, 0);
    chk("R9 pending result not stored", nStore, 0);

    // ---- Test C: internal divider (R6)
    hostWrite(8'h40, mkEntry(1, 2'b00, 0, 2'd0, 6'd9));
    hostWrite(8'h00, 16'h0000);
    hostWrite(8'h01, 16'd9);
    hostWrite(8'h02, 16'd0);
    hostWrite(8'h03, 16'd3);
    for (int i = 0; i < 4; i++) expectSample(6'd9, 2'd0, 0, 16'(i), 16'(16'h0400 + i));
    startTimes.delete();
    hostWrite(8'h07, 16'h0);
    waitIdle(200);
    chk("R6 divider sample count", startTimes.size(), 4);
    for (int i = 1; i < 4 && i < startTimes.size(); i++)
      chk("R6 divider tick spacing N+1", startTimes[i] - startTimes[i-1], 10);
    chk("R7 divider run ended", running, 0);

    chk("R2 conversion queue drained", convQ.size(), 0);
    chk("R3 store queue drained", storeQ.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule